// File: doc/BRIEF.md
# Parallel EEPROM Device Port

This block is the device side of a byte-wide parallel EEPROM with active-low chip-select, output-enable and write-enable pins. It samples those pins, the address and the incoming data in a fast system clock domain. From them it decodes standby, read and write cycles, serves stored bytes onto the data bus through a tri-state enable, and stores written bytes into an internal array. Every accepted write is followed by a self-timed busy period. The byte is only committed to the array when that period expires.

The data bus is split into `data_in`, `data_out` and the tri-state enable `data_oe`, which a pad ring combines into one bidirectional bus. `ADDR_W` sets the array size to 2^ADDR_W bytes. A 32K x 8 part uses `ADDR_W = 15`. The default build keeps the array small.

A single state machine (`eep_fsm`) has five states: `S_IDLE`, `S_RD_WAIT`, `S_RD_DRIVE`, `S_WR_OPEN` and `S_WR_BUSY`. Its transitions are:
- **idle to read-wait**: the read condition is present.
- **read-wait to drive**: the access delay has elapsed.
- **read-wait or drive to idle**: the read condition ends.
- **idle to write-open**: the write condition rises. The address is captured at this point.
- **write-open to busy**: chip-select or write-enable returns high. The data is frozen at this point.
- **busy to idle**: the write counter expires, and the byte is committed.

Top module: `eep_port`

## Requirements
- R1: With chip-select low, output-enable low and write-enable high, `data_oe` rises exactly READ_DELAY+3 clock edges after the pins show that condition, and `data_out` then carries the byte stored at `addr`. Before that, `data_oe` is 0.
- R2: When chip-select or output-enable goes high, `data_oe` drops to 0 within 2 clock edges. It stays 1 for the first of those edges.
- R3: A write happens only when chip-select and write-enable are both low with output-enable high. With output-enable low, the byte is not changed, `busy` stays 0 and `data_oe` stays 0.
- R4: The write address is taken when the later of the two falling edges (chip-select, write-enable) is seen. An address present before that edge is not used.
- R5: The write data is the value present just before the earlier of the two rising edges (chip-select, write-enable). Data changes after that edge do not reach the array.
- R6: After the data is latched, `busy` is 1 for exactly WRITE_CYCLES clock cycles. The array holds the new byte once `busy` falls.
- R7: While `busy` is 1, write attempts are ignored, including one still held when `busy` ends. Read requests do not drive the bus.
- R8: After reset, `data_oe`, `data_out` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Data from the bus during writes |
| data_out | output | DATA_W | Data to the bus during reads, 0 when not driving |
| data_oe | output | 1 | Tri-state enable for the data bus |
| busy | output | 1 | Self-timed write in progress |

## Verification
The bench runs writes in all four edge orderings, with a decoy address before the later falling edge and changed data after the earlier rising edge. A design that latched on the wrong edge would store the decoy address or the late data. It measures the read access delay and the bus release to the exact clock edge. An off-by-one counter or a stale enable shows up as a wrong edge count. It performs a write while output-enable is low, and a write and a read while busy. Wrongly accepting either write corrupts a byte that is read back later, and a read served while busy shows as a driven bus. Randomised write/read sequences against a bench model also check the busy length on every write.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_WAIT,
        S_RD_DRIVE,
        S_WR_OPEN,
        S_WR_BUSY
    } eep_state_e;
endpackage

// File: rtl/eep_sync.sv
// Two-stage sampler for asynchronous pins; reset value is per bit.
module eep_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/eep_array.sv
// Byte store: synchronous write, asynchronous read.
module eep_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_fsm.sv
// Cycle decoder: read access delay, write edge latching, busy timer.
module eep_fsm
    import eep_pkg::*;
#(
    parameter int AW           = 11,
    parameter int DW           = 8,
    parameter int READ_DELAY   = 19,
    parameter int WRITE_CYCLES = 625000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          oe_s,
    input  logic          we_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          drive_en,
    output logic          busy,
    output logic          commit,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int MAXC = (READ_DELAY > WRITE_CYCLES) ? READ_DELAY : WRITE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    eep_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [DW-1:0] data_q, data_d;
    logic          wr_last;
    logic          rd_lvl, wr_lvl;

    assign rd_lvl = !cs_s && !oe_s && we_s;
    assign wr_lvl = !cs_s && !we_s && oe_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            wr_last <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
            wr_last <= wr_lvl;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        addr_d  = addr_q;
        data_d  = data_q;
        unique case (state_q)
            S_IDLE: begin
                if (wr_lvl && !wr_last) begin
                    state_d = S_WR_OPEN;
                    addr_d  = addr_s;
                    data_d  = data_s;
                end else if (rd_lvl) begin
                    state_d = S_RD_WAIT;
                    cnt_d   = CW'(READ_DELAY - 1);
                end
            end
            S_RD_WAIT: begin
                if (!rd_lvl)            state_d = S_IDLE;
                else if (cnt_q == '0)   state_d = S_RD_DRIVE;
                else                    cnt_d   = cnt_q - 1'b1;
            end
            S_RD_DRIVE: begin
                if (!rd_lvl) state_d = S_IDLE;
            end
            S_WR_OPEN: begin
                if (cs_s || we_s) begin
                    state_d = S_WR_BUSY;
                    cnt_d   = CW'(WRITE_CYCLES - 1);
                end else if (oe_s) begin
                    data_d = data_s;
                end
            end
            S_WR_BUSY: begin
                if (cnt_q == '0) state_d = S_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        drive_en = (state_q == S_RD_DRIVE) && rd_lvl;
        busy     = (state_q == S_WR_BUSY);
        commit   = (state_q == S_WR_BUSY) && (cnt_q == '0);
        wr_addr  = addr_q;
        wr_data  = data_q;
    end
endmodule

// File: rtl/eep_port.sv
module eep_port #(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int READ_DELAY   = 19,
    parameter int WRITE_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              busy
);
    localparam int SW = 3 + ADDR_W + DATA_W;
    localparam logic [SW-1:0] SYNC_RST = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    logic [SW-1:0]     pins_raw, pins_s;
    logic              cs_s, oe_s, we_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              drive_en, commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    assign pins_raw = {cs_n, oe_n, we_n, addr, data_in};

    eep_sync #(.W(SW), .RST_VAL(SYNC_RST)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
    );

    assign cs_s   = pins_s[SW-1];
    assign oe_s   = pins_s[SW-2];
    assign we_s   = pins_s[SW-3];
    assign addr_s = pins_s[ADDR_W+DATA_W-1:DATA_W];
    assign data_s = pins_s[DATA_W-1:0];

    eep_fsm #(
        .AW(ADDR_W), .DW(DATA_W),
        .READ_DELAY(READ_DELAY), .WRITE_CYCLES(WRITE_CYCLES)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .oe_s(oe_s), .we_s(we_s),
        .addr_s(addr_s), .data_s(data_s),
        .drive_en(drive_en), .busy(busy), .commit(commit),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    eep_array #(.AW(ADDR_W), .DW(DATA_W)) i_array (
        .clk(clk), .wr_en(commit), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(addr_s), .rd_data(rd_data)
    );

    assign data_oe  = drive_en;
    assign data_out = drive_en ? rd_data : '0;
endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_s,
    input logic          oe_s,
    input logic          we_s,
    input logic          data_oe,
    input logic          busy,
    input logic          commit,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data
);
    a_r2_release_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s || oe_s) |-> !data_oe);

    a_r3_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_s |-> !data_oe);

    a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !data_oe);

    a_r5_latch_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cs_s || we_s));

    a_r6_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(wr_addr) && $stable(wr_data)));

    a_r6_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);

    a_r6_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
endmodule

bind eep_port eep_checker #(.AW(ADDR_W), .DW(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .cs_s(cs_s), .oe_s(oe_s), .we_s(we_s),
    .data_oe(data_oe), .busy(busy), .commit(commit),
    .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/test_eep_port.sv
module test_eep_port;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int RD = 5;
    localparam int WC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] data_out;
    logic          data_oe, busy;

    int n_tests = 0;
    int n_fail  = 0;
    int busy_total = 0;
    logic [DW-1:0] mdl [1 << AW];
    bit            known [1 << AW];

    always #4 clk = ~clk;

    eep_port #(.ADDR_W(AW), .DATA_W(DW), .READ_DELAY(RD), .WRITE_CYCLES(WC)) i_eep_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(din), .data_out(data_out), .data_oe(data_oe), .busy(busy)
    );

    always @(negedge clk) if (busy === 1'b1) busy_total <= busy_total + 1;

    function automatic logic [AW-1:0] pool_addr(input int i);
        return AW'((i * 97 + 5) % (1 << AW));
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // write sequence at the pins; decoy address before the later fall, changed data after the earlier rise
    task automatic pin_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit cs_first, input bit we_rise_first, input bit oe_low);
        logic [AW-1:0] junk;
        junk = a ^ AW'(11'h5A5);
        oe_n = oe_low ? 1'b0 : 1'b1;
        addr = junk; din = ~d;
        if (cs_first) cs_n = 1'b0; else we_n = 1'b0;
        idle(4);
        addr = a; din = d;
        if (cs_first) we_n = 1'b0; else cs_n = 1'b0;
        idle(5);
        if (we_rise_first) we_n = 1'b1; else cs_n = 1'b1;
        idle(3);
        din = ~d; addr = junk;
        idle(1);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        idle(2);
    endtask

    task automatic wait_not_busy();
        while (busy) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit cs_first, input bit we_rise_first);
        int start;
        start = busy_total;
        pin_write(a, d, cs_first, we_rise_first, 1'b0);
        wait_not_busy();
        chk(busy_total - start == WC, "R6", "busy length", busy_total - start, WC);
        mdl[a] = d; known[a] = 1'b1;
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        idle(RD + 3);
        chk(data_oe === 1'b1, req, "read enable", int'(data_oe), 1);
        chk(data_out === exp, req, "read data", int'(data_out), int'(exp));
        cs_n = 1'b1; oe_n = 1'b1;
        idle(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < (1 << AW); i++) known[i] = 1'b0;
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(data_oe === 1'b0, "R8", "oe in reset", int'(data_oe), 0);
        chk(busy === 1'b0, "R8", "busy in reset", int'(busy), 0);
        chk(data_out === '0, "R8", "data in reset", int'(data_out), 0);
        rst_n = 1'b1;
        idle(3);

        // R4/R5: all four edge orderings
        do_write(pool_addr(0), 8'h3C, 1'b1, 1'b1);
        rd_check(pool_addr(0), 8'h3C, "R4");
        do_write(pool_addr(1), 8'hC5, 1'b1, 1'b0);
        rd_check(pool_addr(1), 8'hC5, "R5");
        do_write(pool_addr(2), 8'h5A, 1'b0, 1'b1);
        rd_check(pool_addr(2), 8'h5A, "R4");
        do_write(pool_addr(3), 8'h81, 1'b0, 1'b0);
        rd_check(pool_addr(3), 8'h81, "R5");

        // R1: exact access delay; R2: release on output-enable
        addr = pool_addr(0); cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        idle(RD + 2);
        chk(data_oe === 1'b0, "R1", "enable before delay", int'(data_oe), 0);
        idle(1);
        chk(data_oe === 1'b1, "R1", "enable at delay", int'(data_oe), 1);
        chk(data_out === 8'h3C, "R1", "data at delay", int'(data_out), 8'h3C);
        oe_n = 1'b1;
        idle(1);
        chk(data_oe === 1'b1, "R2", "enable one edge after oe", int'(data_oe), 1);
        idle(1);
        chk(data_oe === 1'b0, "R2", "released after oe", int'(data_oe), 0);
        // R2: release on chip-select
        oe_n = 1'b0;
        idle(RD + 4);
        cs_n = 1'b1;
        idle(2);
        chk(data_oe === 1'b0, "R2", "released after cs", int'(data_oe), 0);
        oe_n = 1'b1;
        idle(3);

        // R3: write attempt with output-enable low
        begin
            int start;
            start = busy_total;
            pin_write(pool_addr(0), 8'hA5, 1'b1, 1'b1, 1'b1);
            idle(4);
            chk(busy_total == start, "R3", "busy on oe-low write", busy_total - start, 0);
            chk(data_oe === 1'b0, "R3", "drive on oe-low write", int'(data_oe), 0);
            rd_check(pool_addr(0), 8'h3C, "R3");
        end

        // R7: read and write while busy
        begin
            bit seen_drive;
            pin_write(pool_addr(4), 8'h11, 1'b1, 1'b1, 1'b0);
            mdl[pool_addr(4)] = 8'h11; known[pool_addr(4)] = 1'b1;
            chk(busy === 1'b1, "R7", "busy after write", int'(busy), 1);
            seen_drive = 1'b0;
            addr = pool_addr(1); cs_n = 1'b0; oe_n = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (data_oe) seen_drive = 1'b1;
            end
            cs_n = 1'b1; oe_n = 1'b1;
            idle(2);
            chk(seen_drive == 1'b0, "R7", "read served while busy", int'(seen_drive), 0);
            pin_write(pool_addr(1), 8'h77, 1'b0, 1'b0, 1'b0);
            // held write across the end of busy
            addr = pool_addr(2); din = 8'hEE; cs_n = 1'b0; we_n = 1'b0;
            wait_not_busy();
            idle(6);
            cs_n = 1'b1; we_n = 1'b1;
            idle(4);
            chk(busy === 1'b0, "R7", "held write accepted", int'(busy), 0);
            rd_check(pool_addr(1), 8'hC5, "R7");
            rd_check(pool_addr(2), 8'h5A, "R7");
            rd_check(pool_addr(4), 8'h11, "R6");
        end

        // random mix
        for (int it = 0; it < 24; it++) begin
            int idx;
            idx = int'($urandom % 16);
            if (($urandom % 2) == 0 || !known[pool_addr(idx)]) begin
                do_write(pool_addr(idx), DW'($urandom), bit'($urandom % 2), bit'($urandom % 2));
            end else begin
                rd_check(pool_addr(idx), mdl[pool_addr(idx)], "R1");
            end
        end
        for (int i = 0; i < 16; i++) begin
            if (known[pool_addr(i)]) rd_check(pool_addr(i), mdl[pool_addr(i)], "R6");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule